// File: doc/BRIEF.md
# Byte-Lane Peripheral Bridge

This block connects one 32-bit bus master to a set of peripherals whose data ports are eight bits wide. Each master cycle is routed to exactly one peripheral, chosen by comparing the address against a base and mask pair for each peripheral. These pairs are set by parameters. The peripheral sees the shared address, the write enable and a single write byte. That byte is taken from the lane of the master's write word that the two low address bits name.

Read data comes back as one byte. It is placed into the big-endian lane of the 32-bit return word, and the other three lanes are zero. The acknowledge from the addressed peripheral goes back to the master in the same cycle.

There is no fallback target. A cycle whose address falls in no region gets a one-cycle error response from the bridge. A write whose byte-select bit for the addressed lane is clear is completed by the bridge without touching any peripheral.

Top module: `byteLaneBridge`

## Requirements
- R1: Peripheral i is selected when (mAdr & MASK_i) == BASE_i. When several regions match, the lowest index wins. Only the selected peripheral sees its sCyc and sStb high, and only while mCyc and mStb are both high.
- R2: sDatW carries the byte of mDatW given by mAdr[1:0]: 0 gives bits 31:24, 1 gives 23:16, 2 gives 15:8 and 3 gives 7:0. sAdr equals mAdr and sWe equals mWe.
- R3: The selected peripheral's read byte appears on mDatR in the same lane mapping as R2. All other lanes of mDatR are zero.
- R4: mAck equals the selected peripheral's sAck in the same cycle. The sAck of unselected peripherals has no effect on mAck.
- R5: A cycle (mCyc and mStb high) whose address matches no region strobes no peripheral. It raises mErr for exactly one cycle, starting after the first rising edge of the request.
- R6: A write whose byte-select bit mSel[3 - mAdr[1:0]] is 0 strobes no peripheral. The bridge answers it with a one-cycle mAck after the first rising edge, and mErr stays low. Reads are forwarded regardless of mSel.
- R7: During and after reset, with no request pending, mAck and mErr are low and no peripheral is strobed.
- R8: mAck and mErr are never high together, and at most one sStb bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mAdr | input | ADDR_W | Master address |
| mDatW | input | 32 | Master write word |
| mDatR | output | 32 | Master read word |
| mSel | input | 4 | Master byte selects, bit 3 for bits 31:24 |
| mWe | input | 1 | Master write enable |
| mCyc | input | 1 | Master cycle |
| mStb | input | 1 | Master strobe |
| mAck | output | 1 | Acknowledge to master |
| mErr | output | 1 | Error to master |
| sAdr | output | ADDR_W | Shared peripheral address |
| sDatW | output | 8 | Shared peripheral write byte |
| sWe | output | 1 | Shared peripheral write enable |
| sCyc | output | NUM_SLV | Per-peripheral cycle |
| sStb | output | NUM_SLV | Per-peripheral strobe |
| sDatR | input | NUM_SLV*8 | Per-peripheral read bytes |
| sAck | input | NUM_SLV | Per-peripheral acknowledges |

## Verification
The hardest case to reach is two overlapping regions: an address that lies inside a small region nested within a larger one, where the lower index must win. The default parameters nest a 16-byte region at index 2 inside a 4 KB region at index 3. The bench addresses both the inner window and the outer window outside it. A second hard case is an unselected peripheral that asserts its acknowledge on its own. The slave model in the bench can force acknowledges on any subset of peripherals while it holds back the addressed one, and the bench then checks that mAck stays low.

// File: rtl/blb_pkg.sv
package blb_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;

  typedef struct packed {
    logic [1:0] lane;      // addressed byte lane, big-endian
    logic       fwd;       // request forwarded to a peripheral
    logic       localAck;  // bridge-generated completion
    logic       localErr;  // bridge-generated error
  } strobes_t;
endpackage

// File: rtl/blb_ctrl.sv
module blb_ctrl
  import blb_pkg::*;
#(
  parameter int NUM_SLV = 4,
  parameter int ADDR_W  = 16,
  parameter logic [NUM_SLV*ADDR_W-1:0] BASE = '0,
  parameter logic [NUM_SLV*ADDR_W-1:0] MASK = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  mAdr,
  input  logic [LANES-1:0]   mSel,
  input  logic               mWe,
  input  logic               mCyc,
  input  logic               mStb,
  output logic [NUM_SLV-1:0] slvSel,
  output strobes_t           ctl
);
  logic [NUM_SLV-1:0] hitVec;
  logic [NUM_SLV-1:0] firstHit;
  logic               anyHit;
  logic               req;
  logic [1:0]         lane;
  logic               laneEn;
  logic               maskedWr;
  logic               fwd;
  logic               errQ;
  logic               okQ;

  for (genvar i = 0; i < NUM_SLV; i++) begin : g_dec
    assign hitVec[i] = (mAdr & MASK[i*ADDR_W +: ADDR_W]) == BASE[i*ADDR_W +: ADDR_W];
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    firstHit = '0;
    for (int i = 0; i < NUM_SLV; i++) begin
      if (hitVec[i] && !found) begin
        firstHit[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  assign anyHit   = |hitVec;
  assign req      = mCyc & mStb;
  assign lane     = mAdr[1:0];
  assign laneEn   = mSel[2'd3 - lane];
  assign maskedWr = mWe & ~laneEn;
  assign fwd      = req & anyHit & ~maskedWr;
  assign slvSel   = firstHit & {NUM_SLV{fwd}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errQ <= 1'b0;
      okQ  <= 1'b0;
    end else begin
      errQ <= req & ~anyHit & ~errQ;
      okQ  <= req & anyHit & maskedWr & ~okQ;
    end
  end

  assign ctl.lane     = lane;
  assign ctl.fwd      = fwd;
  assign ctl.localAck = okQ;
  assign ctl.localErr = errQ;
endmodule

// File: rtl/blb_datapath.sv
module blb_datapath
  import blb_pkg::*;
#(
  parameter int NUM_SLV = 4
) (
  input  logic [WORD_W-1:0]         mDatW,
  input  logic                      mCyc,
  input  logic                      mStb,
  input  logic [NUM_SLV-1:0]        slvSel,
  input  strobes_t                  ctl,
  input  logic [NUM_SLV*BYTE_W-1:0] sDatR,
  input  logic [NUM_SLV-1:0]        sAck,
  output logic [BYTE_W-1:0]         sDatW,
  output logic [NUM_SLV-1:0]        sCyc,
  output logic [NUM_SLV-1:0]        sStb,
  output logic [WORD_W-1:0]         mDatR,
  output logic                      mAck
);
  logic [BYTE_W-1:0] rdByte;
  int                laneBase;

  assign laneBase = (LANES - 1 - int'(ctl.lane)) * BYTE_W;

  assign sDatW = mDatW[laneBase +: BYTE_W];
  assign sCyc  = {NUM_SLV{mCyc}} & slvSel;
  assign sStb  = {NUM_SLV{mStb}} & slvSel;

  always_comb begin
    rdByte = '0;
    for (int i = 0; i < NUM_SLV; i++) begin
      rdByte = rdByte | (sDatR[i*BYTE_W +: BYTE_W] & {BYTE_W{slvSel[i]}});
    end
  end

  always_comb begin
    mDatR = '0;
    if (ctl.fwd) mDatR[laneBase +: BYTE_W] = rdByte;
  end

  assign mAck = (|(sAck & slvSel)) | ctl.localAck;
endmodule

// File: rtl/byteLaneBridge.sv
module byteLaneBridge
  import blb_pkg::*;
#(
  parameter int NUM_SLV = 4,
  parameter int ADDR_W  = 16,
  parameter logic [NUM_SLV*ADDR_W-1:0] BASE = {16'h3000, 16'h3000, 16'h2000, 16'h1000},
  parameter logic [NUM_SLV*ADDR_W-1:0] MASK = {16'hF000, 16'hFFF0, 16'hFF00, 16'hF000}
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         mAdr,
  input  logic [31:0]               mDatW,
  output logic [31:0]               mDatR,
  input  logic [3:0]                mSel,
  input  logic                      mWe,
  input  logic                      mCyc,
  input  logic                      mStb,
  output logic                      mAck,
  output logic                      mErr,
  output logic [ADDR_W-1:0]         sAdr,
  output logic [7:0]                sDatW,
  output logic                      sWe,
  output logic [NUM_SLV-1:0]        sCyc,
  output logic [NUM_SLV-1:0]        sStb,
  input  logic [NUM_SLV*8-1:0]      sDatR,
  input  logic [NUM_SLV-1:0]        sAck
);
  logic [NUM_SLV-1:0] slvSel;
  strobes_t           ctl;

  blb_ctrl #(
    .NUM_SLV(NUM_SLV), .ADDR_W(ADDR_W), .BASE(BASE), .MASK(MASK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .mAdr(mAdr), .mSel(mSel), .mWe(mWe),
    .mCyc(mCyc), .mStb(mStb), .slvSel(slvSel), .ctl(ctl)
  );

  blb_datapath #(.NUM_SLV(NUM_SLV)) u_dp (
    .mDatW(mDatW), .mCyc(mCyc), .mStb(mStb), .slvSel(slvSel), .ctl(ctl),
    .sDatR(sDatR), .sAck(sAck), .sDatW(sDatW), .sCyc(sCyc), .sStb(sStb),
    .mDatR(mDatR), .mAck(mAck)
  );

  assign sAdr = mAdr;
  assign sWe  = mWe;
  assign mErr = ctl.localErr;
endmodule

// File: rtl/byteLaneBridge_chk.sv
module byteLaneBridge_chk #(
  parameter int NUM_SLV = 4,
  parameter int ADDR_W  = 16,
  parameter logic [NUM_SLV*ADDR_W-1:0] BASE = '0,
  parameter logic [NUM_SLV*ADDR_W-1:0] MASK = '0
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  mAdr,
  input logic [31:0]        mDatR,
  input logic [3:0]         mSel,
  input logic               mWe,
  input logic               mCyc,
  input logic               mStb,
  input logic               mAck,
  input logic               mErr,
  input logic [NUM_SLV-1:0] sCyc,
  input logic [NUM_SLV-1:0] sStb
);
  logic        anyHitC;
  logic [31:0] laneMaskC;
  logic        reqC;

  always_comb begin
    anyHitC = 1'b0;
    for (int i = 0; i < NUM_SLV; i++)
      if ((mAdr & MASK[i*ADDR_W +: ADDR_W]) == BASE[i*ADDR_W +: ADDR_W]) anyHitC = 1'b1;
  end
  assign laneMaskC = 32'hFF00_0000 >> (mAdr[1:0] * 8);
  assign reqC      = mCyc && mStb;

  AST_ONE_SLAVE:    assert property (@(posedge clk) disable iff (!rstN) $onehot0(sStb));                         // R8
  AST_ACK_XOR_ERR:  assert property (@(posedge clk) disable iff (!rstN) !(mAck && mErr));                       // R8
  AST_ERR_PULSE:    assert property (@(posedge clk) disable iff (!rstN) mErr |=> !mErr);                        // R5
  AST_MISS_ERR:     assert property (@(posedge clk) disable iff (!rstN) (reqC && !anyHitC && !mErr) |=> mErr); // R5
  AST_MISS_NO_STB:  assert property (@(posedge clk) disable iff (!rstN) (reqC && !anyHitC) |-> sStb == '0);    // R5
  AST_IDLE_QUIET:   assert property (@(posedge clk) disable iff (!rstN) !reqC |-> (sStb == '0 && sCyc == '0)); // R7
  AST_LANE_ZERO:    assert property (@(posedge clk) disable iff (!rstN) (mDatR & ~laneMaskC) == '0);           // R3
  AST_MASKED_WR:    assert property (@(posedge clk) disable iff (!rstN)
                      (reqC && mWe && !mSel[2'd3 - mAdr[1:0]]) |-> sStb == '0);                                // R6
endmodule

bind byteLaneBridge byteLaneBridge_chk #(
  .NUM_SLV(NUM_SLV), .ADDR_W(ADDR_W), .BASE(BASE), .MASK(MASK)
) u_chk (
  .clk(clk), .rstN(rstN), .mAdr(mAdr), .mDatR(mDatR), .mSel(mSel), .mWe(mWe),
  .mCyc(mCyc), .mStb(mStb), .mAck(mAck), .mErr(mErr), .sCyc(sCyc), .sStb(sStb)
);

// File: tb/tb_byteLaneBridge.sv
module tb_byteLaneBridge;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] mAdr;
  logic [31:0]   mDatW, mDatR;
  logic [3:0]    mSel;
  logic          mWe, mCyc, mStb, mAck, mErr;
  logic [AW-1:0] sAdr;
  logic [7:0]    sDatW;
  logic          sWe;
  logic [N-1:0]  sCyc, sStb, sAck;
  logic [N*8-1:0] sDatR;
  logic [N-1:0]  ackEn, ackForce;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sAck = (sStb & ackEn) | ackForce;

  byteLaneBridge dut (
    .clk(clk), .rstN(rstN), .mAdr(mAdr), .mDatW(mDatW), .mDatR(mDatR), .mSel(mSel),
    .mWe(mWe), .mCyc(mCyc), .mStb(mStb), .mAck(mAck), .mErr(mErr), .sAdr(sAdr),
    .sDatW(sDatW), .sWe(sWe), .sCyc(sCyc), .sStb(sStb), .sDatR(sDatR), .sAck(sAck)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    mCyc = 0; mStb = 0; mWe = 0; mSel = 4'hF;
  endtask

  task automatic start(input logic [AW-1:0] a, input logic we, input logic [3:0] sel);
    @(negedge clk);
    mAdr = a; mWe = we; mSel = sel; mCyc = 1; mStb = 1;
    #1;
  endtask

  task automatic t_reset();
    rstN = 0; mCyc = 0; mStb = 0; mWe = 0; mSel = 4'hF; mAdr = '0; mDatW = '0;
    ackEn = '1; ackForce = '0; sDatR = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 mAck in reset", {31'd0, mAck}, 32'd0);
    chk("R7 mErr in reset", {31'd0, mErr}, 32'd0);
    chk("R7 sStb in reset", {28'd0, sStb}, 32'd0);
    @(negedge clk); rstN = 1;
    @(posedge clk); #1;
    chk("R7 idle after reset", {26'd0, mAck, mErr, sStb}, 32'd0);
  endtask

  task automatic t_decode();
    logic [AW-1:0] adrs [6] = '{16'h1004, 16'h1FF0, 16'h2004, 16'h3004, 16'h3104, 16'h4000};
    logic [N-1:0]  exps [6] = '{4'b0001, 4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0000};
    for (int k = 0; k < 6; k++) begin
      start(adrs[k], 1'b0, 4'hF);
      chk($sformatf("R1 sStb @%h", adrs[k]), {28'd0, sStb}, {28'd0, exps[k]});
      chk($sformatf("R1 sCyc @%h", adrs[k]), {28'd0, sCyc}, {28'd0, exps[k]});
      idle();
      @(posedge clk);
    end
  endtask

  task automatic t_read();
    logic [31:0] exp;
    sDatR = {8'hD3, 8'hC2, 8'h5A, 8'hB0};
    for (int ln = 0; ln < 4; ln++) begin
      start(16'h2000 + AW'(ln), 1'b0, 4'h0);
      exp = 32'h5A00_0000 >> (ln * 8);
      chk($sformatf("R3 read lane %0d", ln), mDatR, exp);
      chk("R4 ack from selected", {31'd0, mAck}, 32'd1);
      chk("R6 read forwarded with mSel=0", {28'd0, sStb}, 32'd2);
      idle();
    end
    start(16'h3104, 1'b0, 4'hF);
    chk("R3 read lane 0 from slave 3", mDatR, 32'h0000_00D3 << 0 << 24);
    idle();
  endtask

  task automatic t_write();
    logic [7:0] exps [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    mDatW = 32'h1122_3344;
    for (int ln = 0; ln < 4; ln++) begin
      start(16'h1010 + AW'(ln), 1'b1, 4'hF);
      chk($sformatf("R2 write byte lane %0d", ln), {24'd0, sDatW}, {24'd0, exps[ln]});
      chk("R2 sAdr", {16'd0, sAdr}, {16'd0, 16'h1010 + AW'(ln)});
      chk("R2 sWe", {31'd0, sWe}, 32'd1);
      idle();
    end
  endtask

  task automatic t_ack();
    ackEn = 4'b1110; ackForce = 4'b1110;
    start(16'h1000, 1'b0, 4'hF);
    chk("R4 unselected acks ignored", {31'd0, mAck}, 32'd0);
    @(negedge clk); ackEn = '1;
    #1;
    chk("R4 selected ack passes", {31'd0, mAck}, 32'd1);
    idle();
    ackForce = '0;
  endtask

  task automatic t_miss();
    start(16'h4000, 1'b0, 4'hF);
    chk("R5 no strobe on miss", {28'd0, sStb}, 32'd0);
    chk("R5 no err before edge", {31'd0, mErr}, 32'd0);
    @(posedge clk); #1;
    chk("R5 err after edge", {31'd0, mErr}, 32'd1);
    chk("R8 no ack with err", {31'd0, mAck}, 32'd0);
    @(posedge clk); #1;
    chk("R5 err one cycle", {31'd0, mErr}, 32'd0);
    idle();
  endtask

  task automatic t_masked();
    mDatW = 32'hAABB_CCDD;
    start(16'h2000, 1'b1, 4'b0111);
    chk("R6 no strobe on masked write", {28'd0, sStb}, 32'd0);
    chk("R6 no ack before edge", {31'd0, mAck}, 32'd0);
    @(posedge clk); #1;
    chk("R6 ack after edge", {31'd0, mAck}, 32'd1);
    chk("R6 no err", {31'd0, mErr}, 32'd0);
    @(posedge clk); #1;
    chk("R6 ack one cycle", {31'd0, mAck}, 32'd0);
    idle();
    start(16'h2003, 1'b1, 4'b0001);
    chk("R6 enabled lane forwarded", {28'd0, sStb}, 32'd2);
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_decode();
    t_read();
    t_write();
    t_ack();
    t_miss();
    t_masked();
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule